// File: doc/BRIEF.md
# Core Memory Cycle Sequencer

This block runs exactly one memory cycle for each request it accepts, against a store of 37-bit words. Each word holds 36 data bits and one parity bit. A register array stands in for a core stack. Reading that array is destructive: the sense step leaves the word cleared. Every read is therefore finished by a restore half that writes the sensed data back.

There are three cycle kinds.
- **Read/restore:** returns the word, then writes it back.
- **Clear/write:** wipes the word, then stores new port data.
- **Read/modify/write:** returns the word, then parks the stack in a hold state until the port strobes in the replacement data. The write half follows the strobe.

Timing comes from a half-cycle tick count. A full cycle is two halves. With the defaults it is 12 ticks, which is 1.2 µs at a 100 ns clock.

Parity is odd across the 37 stored bits. The parity bit is regenerated on every write and every restore, and checked on every sense. Two maintenance controls act at the point of acceptance:
- **Error stop:** latches a halt after a parity error. The halt lasts until it is cleared.
- **Single step:** admits one cycle per step pulse.

A diagnostic request flag stores a deliberately wrong parity bit, so that the checking path can be exercised.

Top module: `cmem_cycle_seq`

## Requirements
- R1: After reset `busy`, `rmw_wait`, `rd_valid`, `rd_par_err` and `halted` are low. Every word reads back as data 0 with no parity error.
- R2: A request is accepted on a clock edge where the block is idle, `req_valid` is high, `req_kind` is not 2'b11, `halted` is low, and either `step_en` is low or `step_pulse` is high. For read/restore (`req_kind`=2'b00) and clear/write (2'b01), `busy` is high for exactly 2·HALF_TICKS cycles, starting the cycle after acceptance. Requests are not accepted while `busy` is high.
- R3: For read/restore and read/modify/write, `rd_valid` pulses for one cycle, in the (HALF_TICKS+1)-th cycle after the acceptance edge, carrying the stored data on `rd_data`. Clear/write never raises `rd_valid`.
- R4: A read/restore leaves the stored data unchanged, so a following read returns the same value.
- R5: A clear/write stores `req_wdata`, replacing the previous content.
- R6: A read/modify/write (`req_kind`=2'b10) returns the old data and then holds with `rmw_wait` and `busy` high until `wr_strobe`. After the strobe edge it takes HALF_TICKS more cycles, then stores `wr_data` sampled at that edge. `busy` lasts 2·HALF_TICKS+1+g cycles when the strobe comes after g hold cycles.
- R7: Stored parity is odd: the XOR of all 37 bits is 1. `rd_par_err` is high together with `rd_valid` exactly when the sensed word has even parity.
- R8: When `req_bad_par` is high at acceptance, a clear/write or read/modify/write stores the inverted parity bit.
- R9: A restore rewrites the sensed data with correct parity, even after a parity error.
- R10: With `err_stop_en` high, a parity error sets `halted`. The current cycle still completes. While `halted` is high no request is accepted, and `err_clear` lowers it. With `err_stop_en` low, `halted` is never set.
- R11: With `step_en` high, a pending request waits until a cycle with `step_pulse` high.
- R12: A request with `req_kind`=2'b11 is ignored and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 read/restore, 01 clear/write, 10 read/modify/write, 11 none |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 36 | Write data for clear/write |
| req_bad_par | input | 1 | Diagnostic: store inverted parity on this request's write |
| wr_strobe | input | 1 | Write data strobe for the second half of read/modify/write |
| wr_data | input | 36 | Write data for read/modify/write |
| err_stop_en | input | 1 | Halt after a parity error |
| err_clear | input | 1 | Clear the halt |
| step_en | input | 1 | Single-step mode |
| step_pulse | input | 1 | Admit one cycle in single-step mode |
| busy | output | 1 | Cycle in progress |
| rmw_wait | output | 1 | Read/modify/write holding for write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 36 | Sensed data |
| rd_par_err | output | 1 | Parity error on the sensed word, with rd_valid |
| halted | output | 1 | Error stop latched |

## Verification
The bench builds the block with ADDR_W=3 and HALF_TICKS=3, so a full cycle is six clocks. This keeps every phase boundary, and the exact cycle of `rd_valid` and of the fall of `busy`, countable in a short run. The eight-word store makes it cheap to visit both the reset content and the highest address. Holding times of zero, one and two cycles in read/modify/write are exercised. The deliberately wrong parity bit is used to drive both the reporting path and the error-stop path.

// File: rtl/cmem_pkg.sv
package cmem_pkg;
  typedef enum logic [1:0] {
    K_READ = 2'b00,
    K_CLRW = 2'b01,
    K_RMW  = 2'b10,
    K_NONE = 2'b11
  } cyc_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FIRST,
    S_HOLD,
    S_SECOND
  } phase_e;

  localparam int STORE_DATA_W = 36;
endpackage

// File: rtl/cmem_word_store.sv
module cmem_word_store #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  // blank word: zero data with its odd parity bit set
  localparam logic [WORD_W-1:0] BLANK = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK;
    end else if (wr_en) begin
      cells[addr] <= wr_word;
    end else if (clr_en) begin
      cells[addr] <= '0;   // destructive sense leaves the word cleared
    end
  end

  assign rd_word = cells[addr];

  // sense-clear and write-back belong to different halves
  assert_single_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, clr_en}));
endmodule

// File: rtl/cmem_phase_timer.sv
module cmem_phase_timer #(
  parameter int TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || last)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign last = run && (int'(cnt) == TICKS - 1);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < TICKS);
endmodule

// File: rtl/cmem_cycle_seq.sv
module cmem_cycle_seq
  import cmem_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = STORE_DATA_W,
  parameter int HALF_TICKS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_bad_par,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_stop_en,
  input  logic              err_clear,
  input  logic              step_en,
  input  logic              step_pulse,
  output logic              busy,
  output logic              rmw_wait,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_par_err,
  output logic              halted
);
  localparam int WORD_W = DATA_W + 1;

  // parity bit that makes the whole word odd
  function automatic logic odd_fill(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  function automatic logic word_is_odd(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  phase_e            phase;
  cyc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] sensed_q;
  logic              flip_q;
  logic              phase_last;
  logic [WORD_W-1:0] cell_word;
  logic [WORD_W-1:0] commit_word;
  logic [DATA_W-1:0] commit_data;

  // named internal events
  logic accept_evt, clear_evt, sense_evt, commit_evt, sense_bad;

  assign accept_evt = (phase == S_IDLE) && req_valid && (req_kind != K_NONE)
                      && !halted && (!step_en || step_pulse);
  assign clear_evt  = (phase == S_FIRST) && phase_last;
  assign sense_evt  = clear_evt && (kind_q != K_CLRW);
  assign commit_evt = (phase == S_SECOND) && phase_last;
  assign sense_bad  = !word_is_odd(cell_word);

  assign commit_data = (kind_q == K_READ) ? sensed_q : wdata_q;
  assign commit_word = {odd_fill(commit_data) ^ (flip_q && (kind_q != K_READ)),
                        commit_data};

  cmem_phase_timer #(.TICKS(HALF_TICKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  ((phase == S_FIRST) || (phase == S_SECOND)),
    .last (phase_last)
  );

  cmem_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (commit_evt),
    .clr_en (clear_evt),
    .addr   (addr_q),
    .wr_word(commit_word),
    .rd_word(cell_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= S_IDLE;
      kind_q     <= K_READ;
      addr_q     <= '0;
      wdata_q    <= '0;
      sensed_q   <= '0;
      flip_q     <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_par_err <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      rd_par_err <= 1'b0;
      case (phase)
        S_IDLE: if (accept_evt) begin
          phase   <= S_FIRST;
          kind_q  <= cyc_kind_e'(req_kind);
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          flip_q  <= req_bad_par;
        end
        S_FIRST: if (phase_last) begin
          if (sense_evt) begin
            rd_valid   <= 1'b1;
            rd_data    <= cell_word[DATA_W-1:0];
            rd_par_err <= sense_bad;
            sensed_q   <= cell_word[DATA_W-1:0];
          end
          phase <= (kind_q == K_RMW) ? S_HOLD : S_SECOND;
        end
        S_HOLD: if (wr_strobe) begin
          wdata_q <= wr_data;
          phase   <= S_SECOND;
        end
        S_SECOND: if (phase_last) phase <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    halted <= 1'b0;
    else if (sense_evt && sense_bad && err_stop_en) halted <= 1'b1;
    else if (err_clear)                            halted <= 1'b0;
  end

  assign busy     = (phase != S_IDLE);
  assign rmw_wait = (phase == S_HOLD);

  assert_rdv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_rdv_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
  assert_wait_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_wait |-> busy);
  assert_perr_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_par_err |-> rd_valid);
  assert_halt_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !busy) |=> !busy);
  assert_no_halt_unarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_stop_en && !halted) |=> !halted);
  assert_step_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_pulse && !busy) |=> !busy);
  assert_null_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == K_NONE && !busy) |=> !busy);
endmodule

// File: tb/cmem_cycle_seq_bench.sv
module cmem_cycle_seq_bench;
  localparam int AW = 3;
  localparam int H  = 3;
  localparam int VW = 119;
  localparam int NV = 16;

  // {kind[2], addr[3], wdata[36], bad_par, gap[4], rmw_data[36], exp_data[36], exp_err}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd1, 3'd1, 36'hA5A5A5A5A, 1'b0, 4'd0, 36'h0, 36'h0, 1'b0},
    {2'd0, 3'd1, 36'h0, 1'b0, 4'd0, 36'h0, 36'hA5A5A5A5A, 1'b0},
    {2'd0, 3'd1, 36'h0, 1'b0, 4'd0, 36'h0, 36'hA5A5A5A5A, 1'b0},
    {2'd0, 3'd0, 36'h0, 1'b0, 4'd0, 36'h0, 36'h0, 1'b0},
    {2'd2, 3'd1, 36'h0, 1'b0, 4'd2, 36'h123456789, 36'hA5A5A5A5A, 1'b0},
    {2'd0, 3'd1, 36'h0, 1'b0, 4'd0, 36'h0, 36'h123456789, 1'b0},
    {2'd1, 3'd2, 36'hFFFFFFFFF, 1'b1, 4'd0, 36'h0, 36'h0, 1'b0},
    {2'd0, 3'd2, 36'h0, 1'b0, 4'd0, 36'h0, 36'hFFFFFFFFF, 1'b1},
    {2'd0, 3'd2, 36'h0, 1'b0, 4'd0, 36'h0, 36'hFFFFFFFFF, 1'b0},
    {2'd2, 3'd7, 36'h0, 1'b0, 4'd0, 36'h0, 36'h0, 1'b0},
    {2'd0, 3'd7, 36'h0, 1'b0, 4'd0, 36'h0, 36'h0, 1'b0},
    {2'd1, 3'd3, 36'h800000001, 1'b0, 4'd0, 36'h0, 36'h0, 1'b0},
    {2'd0, 3'd3, 36'h0, 1'b0, 4'd0, 36'h0, 36'h800000001, 1'b0},
    {2'd2, 3'd5, 36'h0, 1'b1, 4'd1, 36'h00000000F, 36'h0, 1'b0},
    {2'd0, 3'd5, 36'h0, 1'b0, 4'd0, 36'h0, 36'h00000000F, 1'b1},
    {2'd0, 3'd5, 36'h0, 1'b0, 4'd0, 36'h0, 36'h00000000F, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [35:0]   req_wdata = '0;
  logic          req_bad_par = 1'b0;
  logic          wr_strobe = 1'b0;
  logic [35:0]   wr_data = '0;
  logic          err_stop_en = 1'b0;
  logic          err_clear = 1'b0;
  logic          step_en = 1'b0;
  logic          step_pulse = 1'b0;
  logic          busy, rmw_wait, rd_valid, rd_par_err, halted;
  logic [35:0]   rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmem_cycle_seq #(.ADDR_W(AW), .DATA_W(36), .HALF_TICKS(H)) u_cmem_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bad_par(req_bad_par),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .err_stop_en(err_stop_en),
    .err_clear(err_clear), .step_en(step_en), .step_pulse(step_pulse),
    .busy(busy), .rmw_wait(rmw_wait), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_par_err(rd_par_err), .halted(halted)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [1:0] k, input logic [AW-1:0] a,
                           input logic [35:0] wd, input logic fl, input int gap,
                           input logic [35:0] wd2, output logic [35:0] got,
                           output logic gerr, output int rv_at, output int blen,
                           output int waits);
    int hc;
    hc = 0; rv_at = 0; blen = 0; waits = 0; got = '0; gerr = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; req_bad_par = fl;
    @(negedge clk);
    req_valid = 1'b0; req_bad_par = 1'b0;
    for (int n = 1; n < 100; n++) begin
      if (rd_valid) begin rv_at = n; got = rd_data; gerr = rd_par_err; end
      if (busy) blen++;
      if (rmw_wait) begin
        waits++; hc++; wr_data = wd2; wr_strobe = (hc > gap);
      end else begin
        wr_strobe = 1'b0;
      end
      if (!busy) break;
      @(negedge clk);
    end
    wr_strobe = 1'b0;
  endtask

  // drive a request for three cycles and confirm nothing starts
  task automatic try_ignored(input logic [1:0] k, input logic [AW-1:0] a,
                             input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy, rq, "request must not start a cycle", 64'(busy), 64'd0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual still running expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [35:0] got;
    logic gerr;
    int rv_at, blen, waits;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy after reset", 64'(busy), 64'd0);
    chk(!rd_valid && !rd_par_err, "R1", "read outputs after reset",
        64'({rd_valid, rd_par_err}), 64'd0);
    chk(!halted && !rmw_wait, "R1", "halted/rmw_wait after reset",
        64'({halted, rmw_wait}), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  k;
      logic [35:0] expd;
      logic        expe;
      int          gp;
      k    = VEC[v][118:117];
      gp   = int'(VEC[v][76:73]);
      expd = VEC[v][36:1];
      expe = VEC[v][0];
      run_cycle(k, VEC[v][116:114], VEC[v][113:78], VEC[v][77], gp,
                VEC[v][72:37], got, gerr, rv_at, blen, waits);
      if (k == 2'd2) begin
        chk(blen == 2*H + 1 + gp, "R6", "rmw busy length", 64'(blen), 64'(2*H + 1 + gp));
        chk(waits == gp + 1, "R6", "rmw hold cycles", 64'(waits), 64'(gp + 1));
      end else begin
        chk(blen == 2*H, "R2", "busy length", 64'(blen), 64'(2*H));
      end
      if (k == 2'd1) begin
        chk(rv_at == 0, "R3", "clear/write raised rd_valid", 64'(rv_at), 64'd0);
      end else begin
        chk(rv_at == H + 1, "R3", "rd_valid cycle", 64'(rv_at), 64'(H + 1));
        // R4 R5 R6 stored-data checks, R7 R8 R9 parity
        chk(got == expd, "R4", "read data", 64'(got), 64'(expd));
        chk(gerr == expe, "R7", "parity error flag", 64'(gerr), 64'(expe));
      end
    end
    chk(!halted, "R10", "halt without error stop armed", 64'(halted), 64'd0);

    // R12 null kind
    try_ignored(2'b11, 3'd1, "R12");

    // R11 single step
    step_en = 1'b1;
    try_ignored(2'b00, 3'd1, "R11");
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 3'd1; step_pulse = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; step_pulse = 1'b0;
    chk(busy, "R11", "step pulse admits cycle", 64'(busy), 64'd1);
    while (busy) @(negedge clk);
    step_en = 1'b0;

    // R10 error stop, R8 bad parity write, R9 restore repair
    err_stop_en = 1'b1;
    run_cycle(2'b01, 3'd4, 36'h1, 1'b1, 0, 36'h0, got, gerr, rv_at, blen, waits);
    run_cycle(2'b00, 3'd4, 36'h0, 1'b0, 0, 36'h0, got, gerr, rv_at, blen, waits);
    chk(gerr, "R8", "inverted parity reported", 64'(gerr), 64'd1);
    chk(blen == 2*H, "R10", "faulted cycle completes", 64'(blen), 64'(2*H));
    chk(halted, "R10", "halt latched", 64'(halted), 64'd1);
    try_ignored(2'b00, 3'd4, "R10");
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
    chk(!halted, "R10", "halt cleared", 64'(halted), 64'd0);
    err_stop_en = 1'b0;
    run_cycle(2'b00, 3'd4, 36'h0, 1'b0, 0, 36'h0, got, gerr, rv_at, blen, waits);
    chk(got == 36'h1, "R9", "data after restore", 64'(got), 64'h1);
    chk(!gerr, "R9", "parity regenerated by restore", 64'(gerr), 64'd0);
    // R5 overwrite
    run_cycle(2'b01, 3'd4, 36'hC0FFEE123, 1'b0, 0, 36'h0, got, gerr, rv_at, blen, waits);
    run_cycle(2'b00, 3'd4, 36'h0, 1'b0, 0, 36'h0, got, gerr, rv_at, blen, waits);
    chk(got == 36'hC0FFEE123, "R5", "clear/write replaces word", 64'(got), 64'hC0FFEE123);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule